// File: doc/BRIEF.md
# Delayed-Write Load Forwarding Bypass

This block sits beside a synchronous cache data RAM whose write port runs one cycle behind tag matching, and whose read port captures its address a cycle ahead of the lookup. Because of this skew, a load can read a RAM row that is still missing bytes written in the load's own lookup cycle or in the cycle before it. The bypass keeps a short two-deep record of recent writes and patches those bytes into the RAM read data, so the load returns the newest contents of the row.

Each cycle the caller presents the write landing on the RAM that cycle: row, way, 64-bit data, byte selects and a write kind. It also presents the load in its lookup cycle: row and way. One cycle later the caller supplies the RAM output for that load on `ram_rdata`, and `ld_data` carries the merged result in the same cycle. All forwarding decisions are made in the lookup cycle and held in registers. The output multiplexer therefore depends only on registered selects and the RAM data.

Top module: `store_fwd_bypass`

## Requirements
- R1: If a load looked up in cycle T has no write to its row and way in cycle T-1, and no store to it in cycle T, then `ld_data` in cycle T+1 equals `ram_rdata`. This also applies when `ld_valid` was low in cycle T. The RAM output supplied in T+1 already holds every write up to cycle T-2.
- R2: A store (`wr_kind` = 0) in cycle T to the row and way of a load looked up in cycle T has its selected bytes appear in `ld_data` in cycle T+1.
- R3: A write in cycle T-1 to the row and way of a load looked up in cycle T has its bytes appear in `ld_data` in cycle T+1.
- R4: Byte lane i (bits 8i+7..8i) is forwarded only when `wr_sel[i]` of a matching store is set. All other lanes come from `ram_rdata`.
- R5: When writes in both T-1 and T match, each lane takes the cycle-T store byte if that store selects the lane, otherwise the cycle-T-1 byte if that write selects it, otherwise the RAM byte.
- R6: A refill write (`wr_kind` = 1) in cycle T-1 forwards all eight lanes of `wr_data`, whatever `wr_sel` holds.
- R7: A zero-fill write (`wr_kind` = 2) in cycle T-1 forwards zero in all eight lanes.
- R8: A refill or zero-fill write in the load's own lookup cycle T is not forwarded to that load.
- R9: A write whose row or way differs from the load's row or way is never forwarded.
- R10: After reset, no write presented before or during reset is forwarded, and `ld_data` equals `ram_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | A write lands on the RAM this cycle |
| wr_kind | input | 2 | 0 store, 1 refill, 2 zero-fill |
| wr_row | input | ROW_W | Row being written |
| wr_way | input | WAY_W | Way being written |
| wr_data | input | DATA_W | Write data |
| wr_sel | input | DATA_W/8 | Byte selects for a store |
| ld_valid | input | 1 | A load is in its lookup cycle |
| ld_row | input | ROW_W | Row of the load |
| ld_way | input | WAY_W | Way of the load |
| ram_rdata | input | DATA_W | RAM read data for last cycle's load |
| ld_data | output | DATA_W | Merged load data |

## Verification
The assertions assume that `wr_kind` only takes the values 0, 1 or 2. They also assume that reset is held from time zero until the first clock edge has passed. The bench draws write kinds only from those three codes. During reset it drives `wr_en` and `ld_valid` low. For random traffic it confines rows and ways to a small set, so that matches in both stages, and their overlaps, occur often.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
  typedef enum logic [1:0] {
    WK_STORE  = 2'd0,
    WK_REFILL = 2'd1,
    WK_ZERO   = 2'd2
  } wr_kind_e;
endpackage

// File: rtl/sfb_fwd_stage.sv
module sfb_fwd_stage #(
  parameter int ROW_W  = 9,
  parameter int WAY_W  = 1,
  parameter int DATA_W = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [ROW_W-1:0]    in_row,
  input  logic [WAY_W-1:0]    in_way,
  input  logic [DATA_W-1:0]   in_data,
  input  logic [DATA_W/8-1:0] in_sel,
  input  logic                in_match_ok,
  input  logic                ld_valid,
  input  logic [ROW_W-1:0]    ld_row,
  input  logic [WAY_W-1:0]    ld_way,
  output logic                q_valid,
  output logic [ROW_W-1:0]    q_row,
  output logic [WAY_W-1:0]    q_way,
  output logic [DATA_W-1:0]   q_data,
  output logic [DATA_W/8-1:0] q_sel,
  output logic [DATA_W/8-1:0] hit_sel_q
);
  localparam int NB = DATA_W / 8;

  logic match;
  assign match = in_valid && in_match_ok && ld_valid &&
                 (in_row == ld_row) && (in_way == ld_way);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid   <= 1'b0;
      hit_sel_q <= '0;
    end else begin
      q_valid   <= in_valid;
      hit_sel_q <= match ? in_sel : {NB{1'b0}};
    end
    q_row  <= in_row;
    q_way  <= in_way;
    q_data <= in_data;
    q_sel  <= in_sel;
  end
endmodule

// File: rtl/sfb_merge.sv
module sfb_merge #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0]   ram_data,
  input  logic [DATA_W-1:0]   near_data,
  input  logic [DATA_W/8-1:0] near_sel,
  input  logic [DATA_W-1:0]   far_data,
  input  logic [DATA_W/8-1:0] far_sel,
  output logic [DATA_W-1:0]   out_data
);
  localparam int NB = DATA_W / 8;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    always_comb begin
      if (near_sel[b])
        out_data[8*b +: 8] = near_data[8*b +: 8];
      else if (far_sel[b])
        out_data[8*b +: 8] = far_data[8*b +: 8];
      else
        out_data[8*b +: 8] = ram_data[8*b +: 8];
    end
  end
endmodule

// File: rtl/store_fwd_bypass.sv
module store_fwd_bypass #(
  parameter int ROW_W    = 9,
  parameter int NUM_WAYS = 2,
  parameter int DATA_W   = 64,
  localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int NB      = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_kind,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NB-1:0]     wr_sel,
  input  logic              ld_valid,
  input  logic [ROW_W-1:0]  ld_row,
  input  logic [WAY_W-1:0]  ld_way,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic [DATA_W-1:0] ld_data
);
  import sfb_pkg::*;

  wr_kind_e    kind;
  logic        is_store;
  logic [DATA_W-1:0] s0_data_in;
  logic [NB-1:0]     s0_sel_in;

  assign kind       = wr_kind_e'(wr_kind);
  assign is_store   = (kind == WK_STORE);
  assign s0_data_in = (kind == WK_ZERO) ? {DATA_W{1'b0}} : wr_data;
  assign s0_sel_in  = is_store ? wr_sel : {NB{1'b1}};

  logic              s1_valid, s2_valid;
  logic [ROW_W-1:0]  s1_row, s2_row;
  logic [WAY_W-1:0]  s1_way, s2_way;
  logic [DATA_W-1:0] s1_data, s2_data;
  logic [NB-1:0]     s1_sel, s2_sel, s1_hit, s2_hit;

  // Stage 1: the write landing in the load's lookup cycle (stores only match)
  sfb_fwd_stage #(.ROW_W(ROW_W), .WAY_W(WAY_W), .DATA_W(DATA_W)) u_stage1 (
    .clk(clk), .rst(rst),
    .in_valid(wr_en), .in_row(wr_row), .in_way(wr_way),
    .in_data(s0_data_in), .in_sel(s0_sel_in), .in_match_ok(is_store),
    .ld_valid(ld_valid), .ld_row(ld_row), .ld_way(ld_way),
    .q_valid(s1_valid), .q_row(s1_row), .q_way(s1_way),
    .q_data(s1_data), .q_sel(s1_sel), .hit_sel_q(s1_hit)
  );

  // Stage 2: the write from one cycle before the lookup (any kind matches)
  sfb_fwd_stage #(.ROW_W(ROW_W), .WAY_W(WAY_W), .DATA_W(DATA_W)) u_stage2 (
    .clk(clk), .rst(rst),
    .in_valid(s1_valid), .in_row(s1_row), .in_way(s1_way),
    .in_data(s1_data), .in_sel(s1_sel), .in_match_ok(1'b1),
    .ld_valid(ld_valid), .ld_row(ld_row), .ld_way(ld_way),
    .q_valid(s2_valid), .q_row(s2_row), .q_way(s2_way),
    .q_data(s2_data), .q_sel(s2_sel), .hit_sel_q(s2_hit)
  );

  sfb_merge #(.DATA_W(DATA_W)) u_merge (
    .ram_data(ram_rdata),
    .near_data(s1_data), .near_sel(s1_hit),
    .far_data(s2_data),  .far_sel(s2_hit),
    .out_data(ld_data)
  );

  AST_NO_LOAD_PASS: assert property (@(posedge clk) disable iff (rst)
    !$past(ld_valid) |-> ld_data == ram_rdata); // R1
  AST_S2_SHIFT: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (s2_data == $past(s1_data) && s2_valid == $past(s1_valid) &&
                     s2_row == $past(s1_row) && s2_way == $past(s1_way) &&
                     s2_sel == $past(s1_sel))); // R3
  AST_FILL_ALL_SEL: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && $past(wr_kind) != 2'd0) |-> s1_sel == {NB{1'b1}}); // R6
  AST_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && $past(wr_kind) == 2'd2) |-> s1_data == {DATA_W{1'b0}}); // R7
  AST_FILL_NO_NEAR: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_kind) != 2'd0) |-> s1_hit == {NB{1'b0}}); // R8
  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ld_data == ram_rdata); // R10
endmodule

// File: tb/store_fwd_bypass_tb.sv
module store_fwd_bypass_tb;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic        v;
    logic [1:0]  k;
    logic [8:0]  row;
    logic        w;
    logic [63:0] d;
    logic [7:0]  s;
  } wr_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_kind = 2'd0;
  logic [8:0]  wr_row = '0;
  logic [0:0]  wr_way = '0;
  logic [63:0] wr_data = '0;
  logic [7:0]  wr_sel = '0;
  logic        ld_valid = 1'b0;
  logic [8:0]  ld_row = '0;
  logic [0:0]  ld_way = '0;
  logic [63:0] ram_rdata = '0;
  logic [63:0] ld_data;

  always #(CLK_P/2) clk = ~clk;

  store_fwd_bypass u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_kind(wr_kind),
    .wr_row(wr_row), .wr_way(wr_way), .wr_data(wr_data), .wr_sel(wr_sel),
    .ld_valid(ld_valid), .ld_row(ld_row), .ld_way(ld_way),
    .ram_rdata(ram_rdata), .ld_data(ld_data)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [63:0] ram [0:1023];
  wr_t   p1, p2;
  logic  pl_v;
  logic [8:0] pl_row;
  logic  pl_way;
  string pl_tag;
  localparam wr_t NONE = '0;

  function automatic logic [63:0] apply_wr(input logic [63:0] old, input wr_t w);
    logic [63:0] r = old;
    if (w.k == 2'd1) r = w.d;
    else if (w.k == 2'd2) r = '0;
    else for (int b = 0; b < 8; b++) if (w.s[b]) r[8*b +: 8] = w.d[8*b +: 8];
    return r;
  endfunction

  function automatic bit hits(input wr_t w, input logic [8:0] row, input logic way);
    return w.v && w.row == row && w.w == way;
  endfunction

  function automatic wr_t mk(input logic [1:0] k, input logic [8:0] row, input logic w,
                             input logic [63:0] d, input logic [7:0] s);
    wr_t r;
    r.v = 1'b1; r.k = k; r.row = row; r.w = w; r.d = d; r.s = s;
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: ld_data=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input wr_t nw, input logic lv, input logic [8:0] lrow,
                      input logic lway, input string tag);
    logic [63:0] exp;
    if (pl_v) ram_rdata = ram[{pl_row, pl_way}];
    else ram_rdata = {$urandom, $urandom};
    #1;
    if (pl_v) begin
      exp = ram_rdata;
      if (hits(p2, pl_row, pl_way)) exp = apply_wr(exp, p2);
      if (hits(p1, pl_row, pl_way) && p1.k == 2'd0) exp = apply_wr(exp, p1);
      check(pl_tag, ld_data, exp);
    end
    if (p2.v) ram[{p2.row, p2.w}] = apply_wr(ram[{p2.row, p2.w}], p2);
    p2 = p1; p1 = nw;
    pl_v = lv; pl_row = lrow; pl_way = lway; pl_tag = tag;
    wr_en = nw.v; wr_kind = nw.k; wr_row = nw.row; wr_way = nw.w;
    wr_data = nw.d; wr_sel = nw.s;
    ld_valid = lv; ld_row = lrow; ld_way = lway;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; wr_en = 1'b0; ld_valid = 1'b0;
    repeat (2) @(negedge clk);
    p1 = NONE; p2 = NONE; pl_v = 1'b0;
    rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1024; i++) ram[i] = {$urandom, $urandom};
    p1 = NONE; p2 = NONE; pl_v = 1'b0; pl_tag = "";
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    // R10: clean state after reset
    step(NONE, 1'b1, 9'd5, 1'b0, "R10");
    step(NONE, 1'b0, '0, 1'b0, "");
    // R2: store in lookup cycle, all bytes
    step(mk(2'd0, 9'd10, 1'b1, 64'h1111_2222_3333_4444, 8'hFF), 1'b1, 9'd10, 1'b1, "R2");
    step(NONE, 1'b0, '0, 1'b0, "");
    // R4: partial byte selects
    step(mk(2'd0, 9'd11, 1'b0, 64'hAABB_CCDD_EEFF_0011, 8'h5A), 1'b1, 9'd11, 1'b0, "R4");
    step(NONE, 1'b0, '0, 1'b0, "");
    // R3: store one cycle before lookup
    step(mk(2'd0, 9'd12, 1'b0, 64'h0F0F_1234_5678_9ABC, 8'h0F), 1'b0, '0, 1'b0, "");
    step(NONE, 1'b1, 9'd12, 1'b0, "R3");
    step(NONE, 1'b0, '0, 1'b0, "");
    // R5: both stages hit, near store wins per lane
    step(mk(2'd0, 9'd13, 1'b1, 64'hA5A5_A5A5_A5A5_A5A5, 8'hFF), 1'b0, '0, 1'b0, "");
    step(mk(2'd0, 9'd13, 1'b1, 64'h5A5A_5A5A_5A5A_5A5A, 8'h33), 1'b1, 9'd13, 1'b1, "R5");
    step(NONE, 1'b0, '0, 1'b0, "");
    // R6: refill one cycle before, selects ignored
    step(mk(2'd1, 9'd14, 1'b0, 64'hDEAD_BEEF_CAFE_F00D, 8'h00), 1'b0, '0, 1'b0, "");
    step(NONE, 1'b1, 9'd14, 1'b0, "R6");
    step(NONE, 1'b0, '0, 1'b0, "");
    // R7: zero-fill one cycle before
    step(mk(2'd2, 9'd15, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF), 1'b0, '0, 1'b0, "");
    step(NONE, 1'b1, 9'd15, 1'b0, "R7");
    step(NONE, 1'b0, '0, 1'b0, "");
    // R8: refill and zero-fill in lookup cycle not forwarded
    step(mk(2'd1, 9'd16, 1'b1, 64'h0123_4567_89AB_CDEF, 8'hFF), 1'b1, 9'd16, 1'b1, "R8");
    step(NONE, 1'b0, '0, 1'b0, "");
    step(NONE, 1'b0, '0, 1'b0, "");
    step(mk(2'd2, 9'd16, 1'b0, 64'h0, 8'hFF), 1'b1, 9'd16, 1'b0, "R8");
    step(NONE, 1'b0, '0, 1'b0, "");
    step(NONE, 1'b0, '0, 1'b0, "");
    // R9: way mismatch, row mismatch
    step(mk(2'd0, 9'd17, 1'b0, 64'h7777_7777_7777_7777, 8'hFF), 1'b1, 9'd17, 1'b1, "R9");
    step(mk(2'd0, 9'd18, 1'b0, 64'h8888_8888_8888_8888, 8'hFF), 1'b1, 9'd19, 1'b0, "R9");
    step(NONE, 1'b0, '0, 1'b0, "");
    // R1: write three cycles before the lookup comes from RAM
    step(mk(2'd0, 9'd20, 1'b0, 64'h9999_0000_9999_0000, 8'hFF), 1'b0, '0, 1'b0, "");
    step(NONE, 1'b0, '0, 1'b0, "");
    step(NONE, 1'b0, '0, 1'b0, "");
    step(NONE, 1'b1, 9'd20, 1'b0, "R1");
    step(NONE, 1'b0, '0, 1'b0, "");
    // R10: store before a mid-run reset must not leak afterwards
    step(mk(2'd0, 9'd21, 1'b0, 64'h4242_4242_4242_4242, 8'hFF), 1'b0, '0, 1'b0, "");
    do_reset();
    step(NONE, 1'b1, 9'd21, 1'b0, "R10");
    step(NONE, 1'b0, '0, 1'b0, "");
    // Random traffic over a small set of rows and ways (R4, R5)
    for (int i = 0; i < 3000; i++) begin
      wr_t w;
      logic [1:0] k;
      k = ($urandom % 4 == 0) ? 2'(1 + $urandom % 2) : 2'd0;
      w = mk(k, 9'(30 + $urandom % 4), 1'($urandom), {$urandom, $urandom}, 8'($urandom));
      if ($urandom % 10 < 3) w = NONE;
      step(w, ($urandom % 10) < 7, 9'(30 + $urandom % 4), 1'($urandom), "R5");
    end
    step(NONE, 1'b0, '0, 1'b0, "");
    finish_run();
  end
endmodule